// File: doc/BRIEF.md
# Grouped Interrupt Expander

This block takes a wide set of peripheral interrupt lines and folds them into a small number of request lines toward a CPU core. By default there are 12 groups of 8 sources. Each source has a pending flag and an enable bit. Each group has an acknowledge latch, so a group raises at most one request until software releases it. The block also keeps one vector word for each source.

When the core starts a vector fetch for a group, the block does two things in the same cycle. It picks the lowest-numbered source in that group that is both pending and enabled, and it returns that source's vector word. The chosen flag is then cleared on the next clock edge. The acknowledge latch is not touched by the fetch; only software can release it.

A mode input and the block's own enable bit decide where vectors are fetched from: a low RAM window, a boot ROM window or the expander's own table. A reset fetch is always steered to the boot ROM. Software reaches the control bit, the acknowledge latches, the enables, the flags and the vector table through a simple register bus.

Top module: `irq_group_expander`

## Requirements
- R1: After reset, every flag reads 0. A flag is set on the clock edge after its `irq_in` bit is high. A flag is also set by writing 1 to its bit at address 0x20+g (write-1-to-set); writing 0 there leaves the flag unchanged.
- R2: `cpu_req[g]` is high whenever group g has at least one flag that is both set and enabled while its acknowledge latch is 0. A high `cpu_req[g]` sets the acknowledge latch on the next edge, which drops the request. A set flag whose enable bit is 0 raises no request.
- R3: The acknowledge latches read at address 0x01, in bits [11:0]. A latch is cleared only by writing 1 to its bit at that address. Writing 0 and vector fetches leave it unchanged.
- R4: When the vector comes from the expander table, a fetch for group g returns, in the same cycle, the vector of the lowest-numbered source that is both set and enabled. When `fetch_en` is high, that flag clears on the next edge.
- R5: When a fetch from the expander table finds no source in the group that is both set and enabled, it returns the vector of the group's source 0 and clears no flag.
- R6: If `irq_in` sets a flag in the same cycle that a fetch clears it, the flag stays set.
- R7: Control bit 0 at address 0x00 enables the expander and resets to 0. `fetch_region` is encoded as 0 = low RAM, 1 = boot ROM, 2 = expander table.
  - With `map_vec` = 0: region 0, `fetch_addr` = 2*(g+1).
  - With `map_vec` = 1 and the enable at 0: region 1, `fetch_addr` = 0x3FFFC0 + 2*(g+1).
  - With `map_vec` = 1 and the enable at 1: region 2, `fetch_addr` = 0x000D40 + 2*(8g+s), where s is the chosen source.
  - Outside region 2, `fetch_vec` is 0 and a fetch clears no flag.
- R8: A fetch with `fetch_rst` = 1 always gives region 1 and `fetch_addr` = 0x3FFFC0, returns vector 0 and clears no flag, whatever the mode and enable.
- R9: Register map:
  - 0x00: control bit 0.
  - 0x01: acknowledge latches.
  - 0x10+g: group g enables, bits [7:0], plain write.
  - 0x20+g: group g flags.
  - 0x80+i: vector word of source i = 8g+s, for i from 0 to 95.
  - `bus_rdata` shows the addressed value in the same cycle and reads 0 at unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 96 | Peripheral request lines; bit 8g+s is source s of group g |
| cpu_req | output | 12 | One request line per group toward the core |
| fetch_en | input | 1 | Vector fetch strobe; lets the chosen flag clear |
| fetch_grp | input | 4 | Group being fetched |
| fetch_rst | input | 1 | Marks a reset-vector fetch |
| map_vec | input | 1 | Vector-map mode bit |
| fetch_region | output | 2 | Vector source region |
| fetch_addr | output | 22 | Vector word address |
| fetch_vec | output | 32 | Vector word from the expander table |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |

## Verification
The bound checker watches several rules on every cycle:
- a request always sets its acknowledge latch, and an acknowledged group stays silent;
- a latch survives until a write-1 clears it;
- a peripheral pulse is never lost from its flag, even when a fetch clears that flag in the same cycle;
- reset fetches and disabled-expander fetches go to the boot ROM, and no vector word is presented outside the table region.

Lowest-index selection, the fallback to source 0 on an empty fetch, the exact vector addresses and the register readback depend on stored contents. Those are shown only by the bench's scenarios, where a behavioural model is compared against the ports each clock.

// File: rtl/irq_exp_pkg.sv
package irq_exp_pkg;
  typedef enum logic [1:0] {
    REG_LOWRAM = 2'd0,
    REG_BOOT   = 2'd1,
    REG_EXP    = 2'd2
  } vec_region_e;

  localparam int A_CTRL     = 'h00;
  localparam int A_ACK      = 'h01;
  localparam int A_EN_BASE  = 'h10;
  localparam int A_FLG_BASE = 'h20;
  localparam int A_VEC_BASE = 'h80;

  localparam int BOOT_BASE  = 'h3FFFC0;
  localparam int EXP_BASE   = 'h000D40;
  localparam int LOW_BASE   = 'h000000;
endpackage

// File: rtl/irq_exp_group.sv
module irq_exp_group #(
  parameter  int GSZ = 8,
  localparam int IW  = $clog2(GSZ)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [GSZ-1:0] set_i,
  input  logic           en_we_i,
  input  logic [GSZ-1:0] en_wdata_i,
  input  logic           fetch_i,
  input  logic           ack_clr_i,
  output logic [GSZ-1:0] flag_o,
  output logic [GSZ-1:0] en_o,
  output logic           ack_o,
  output logic           req_o,
  output logic [IW-1:0]  pick_o
);
  logic [GSZ-1:0] flag_q, flag_n, en_q, en_n, pend, clr_mask;
  logic           ack_q, ack_n, any;
  logic [IW-1:0]  pick;

  always_comb pend = flag_q & en_q;

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int i = GSZ - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any  = 1'b1;
        pick = IW'(i);
      end
    end
  end

  always_comb begin
    clr_mask = '0;
    if (fetch_i && any) clr_mask[pick] = 1'b1;
    flag_n = (flag_q & ~clr_mask) | set_i;   // set beats fetch clear
    en_n   = en_we_i ? en_wdata_i : en_q;
    req_o  = any & ~ack_q;
    ack_n  = (ack_q & ~ack_clr_i) | req_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      ack_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      if (en_we_i) en_q <= en_n;
      ack_q  <= ack_n;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign ack_o  = ack_q;
  assign pick_o = pick;
endmodule

// File: rtl/irq_exp_vtab.sv
module irq_exp_vtab #(
  parameter  int NSRC = 96,
  parameter  int VW   = 32,
  localparam int IW   = $clog2(NSRC)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [VW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_a_i,
  output logic [VW-1:0] rdata_a_o,
  input  logic [IW-1:0] ridx_b_i,
  output logic [VW-1:0] rdata_b_o
);
  logic [VW-1:0] mem [NSRC];

  always_ff @(posedge clk) begin
    if (we_i && (int'(widx_i) < NSRC)) mem[widx_i] <= wdata_i;
  end

  always_comb begin
    rdata_a_o = (int'(ridx_a_i) < NSRC) ? mem[ridx_a_i] : '0;
    rdata_b_o = (int'(ridx_b_i) < NSRC) ? mem[ridx_b_i] : '0;
  end
endmodule

// File: rtl/irq_exp_vmap.sv
module irq_exp_vmap
  import irq_exp_pkg::*;
#(
  parameter  int NGRP = 12,
  parameter  int NSRC = 96,
  parameter  int PAW  = 22,
  localparam int GW   = $clog2(NGRP),
  localparam int SIW  = $clog2(NSRC)
) (
  input  logic           fetch_rst_i,
  input  logic           map_vec_i,
  input  logic           ctrl_en_i,
  input  logic [GW-1:0]  grp_i,
  input  logic [SIW-1:0] src_idx_i,
  output vec_region_e    region_o,
  output logic [PAW-1:0] addr_o
);
  logic [PAW-1:0] core_ofs, exp_ofs;

  always_comb begin
    core_ofs = (PAW'(grp_i) + PAW'(1)) << 1;
    exp_ofs  = PAW'(src_idx_i) << 1;
    if (fetch_rst_i) begin
      region_o = REG_BOOT;
      addr_o   = PAW'(BOOT_BASE);
    end else if (!map_vec_i) begin
      region_o = REG_LOWRAM;
      addr_o   = PAW'(LOW_BASE) + core_ofs;
    end else if (!ctrl_en_i) begin
      region_o = REG_BOOT;
      addr_o   = PAW'(BOOT_BASE) + core_ofs;
    end else begin
      region_o = REG_EXP;
      addr_o   = PAW'(EXP_BASE) + exp_ofs;
    end
  end
endmodule

// File: rtl/irq_group_expander.sv
module irq_group_expander
  import irq_exp_pkg::*;
#(
  parameter  int NGRP = 12,
  parameter  int GSZ  = 8,
  parameter  int VW   = 32,
  parameter  int AW   = 8,
  parameter  int PAW  = 22,
  localparam int NSRC = NGRP * GSZ,
  localparam int GW   = $clog2(NGRP),
  localparam int IW   = $clog2(GSZ),
  localparam int SIW  = $clog2(NSRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    irq_in,
  output logic [NGRP-1:0]    cpu_req,
  input  logic               fetch_en,
  input  logic [GW-1:0]      fetch_grp,
  input  logic               fetch_rst,
  input  logic               map_vec,
  output logic [1:0]         fetch_region,
  output logic [PAW-1:0]     fetch_addr,
  output logic [VW-1:0]      fetch_vec,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [VW-1:0]      bus_wdata,
  output logic [VW-1:0]      bus_rdata
);
  // reset synchronizer
  logic rs0_q, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q  <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rs0_q  <= 1'b1;
      rst_sn <= rs0_q;
    end
  end

  int             a;
  logic           ctrl_q, ctrl_n, ctrl_we;
  logic [NGRP-1:0] ack_clr, ack_all, en_we, fetch_hit;
  logic [NSRC-1:0] flag_all, en_all;
  logic [IW-1:0]  pick_arr [NGRP];
  logic [IW-1:0]  pick_sel;
  logic [SIW-1:0] src_idx, vec_widx, vec_ridx;
  logic           grp_ok, vec_hit, fetch_do;
  logic [VW-1:0]  vt_fetch, vt_bus;
  vec_region_e    region;

  always_comb begin
    a        = int'(bus_addr);
    ctrl_we  = bus_we && (a == A_CTRL);
    ctrl_n   = ctrl_we ? bus_wdata[0] : ctrl_q;
    ack_clr  = (bus_we && (a == A_ACK)) ? bus_wdata[NGRP-1:0] : '0;
    vec_hit  = (a >= A_VEC_BASE) && (a < A_VEC_BASE + NSRC);
    vec_widx = vec_hit ? SIW'(a - A_VEC_BASE) : '0;
    vec_ridx = vec_widx;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      ctrl_q <= 1'b0;
    else if (ctrl_we) ctrl_q <= ctrl_n;
  end

  // fetch decode
  always_comb begin
    grp_ok   = int'(fetch_grp) < NGRP;
    pick_sel = grp_ok ? pick_arr[fetch_grp] : '0;
    src_idx  = grp_ok ? (SIW'(fetch_grp) * SIW'(GSZ) + SIW'(pick_sel)) : '0;
    fetch_do = fetch_en && (region == REG_EXP);
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GSZ-1:0] sw_set;
    assign sw_set       = (bus_we && (a == A_FLG_BASE + g)) ? bus_wdata[GSZ-1:0] : '0;
    assign en_we[g]     = bus_we && (a == A_EN_BASE + g);
    assign fetch_hit[g] = fetch_do && (int'(fetch_grp) == g);

    irq_exp_group #(.GSZ(GSZ)) u_grp (
      .clk        (clk),
      .rst_n      (rst_sn),
      .set_i      (irq_in[g*GSZ +: GSZ] | sw_set),
      .en_we_i    (en_we[g]),
      .en_wdata_i (bus_wdata[GSZ-1:0]),
      .fetch_i    (fetch_hit[g]),
      .ack_clr_i  (ack_clr[g]),
      .flag_o     (flag_all[g*GSZ +: GSZ]),
      .en_o       (en_all[g*GSZ +: GSZ]),
      .ack_o      (ack_all[g]),
      .req_o      (cpu_req[g]),
      .pick_o     (pick_arr[g])
    );
  end

  irq_exp_vtab #(.NSRC(NSRC), .VW(VW)) u_vtab (
    .clk       (clk),
    .we_i      (bus_we && vec_hit),
    .widx_i    (vec_widx),
    .wdata_i   (bus_wdata),
    .ridx_a_i  (src_idx),
    .rdata_a_o (vt_fetch),
    .ridx_b_i  (vec_ridx),
    .rdata_b_o (vt_bus)
  );

  irq_exp_vmap #(.NGRP(NGRP), .NSRC(NSRC), .PAW(PAW)) u_vmap (
    .fetch_rst_i (fetch_rst),
    .map_vec_i   (map_vec),
    .ctrl_en_i   (ctrl_q),
    .grp_i       (fetch_grp),
    .src_idx_i   (src_idx),
    .region_o    (region),
    .addr_o      (fetch_addr)
  );

  assign fetch_region = region;
  assign fetch_vec    = (region == REG_EXP) ? vt_fetch : '0;

  // register read mux
  always_comb begin
    bus_rdata = '0;
    if (a == A_CTRL) bus_rdata[0] = ctrl_q;
    if (a == A_ACK)  bus_rdata[NGRP-1:0] = ack_all;
    for (int g = 0; g < NGRP; g++) begin
      if (a == A_EN_BASE + g)  bus_rdata[GSZ-1:0] = en_all[g*GSZ +: GSZ];
      if (a == A_FLG_BASE + g) bus_rdata[GSZ-1:0] = flag_all[g*GSZ +: GSZ];
    end
    if (vec_hit) bus_rdata = vt_bus;
  end
endmodule

// File: rtl/irq_exp_chk.sv
module irq_exp_chk #(
  parameter  int NGRP = 12,
  parameter  int GSZ  = 8,
  parameter  int VW   = 32,
  parameter  int AW   = 8,
  parameter  int PAW  = 22,
  localparam int NSRC = NGRP * GSZ
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_in,
  input logic [NSRC-1:0] flag_all,
  input logic [NGRP-1:0] ack_all,
  input logic [NGRP-1:0] cpu_req,
  input logic            ctrl_q,
  input logic            fetch_rst,
  input logic            map_vec,
  input logic [1:0]      fetch_region,
  input logic [PAW-1:0]  fetch_addr,
  input logic [VW-1:0]   fetch_vec,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [VW-1:0]   bus_wdata
);
  localparam logic [1:0] RG_BOOT = 2'd1;
  localparam logic [1:0] RG_EXP  = 2'd2;

  logic live_q;
  logic ack_wr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end
  assign ack_wr = bus_we && (int'(bus_addr) == 1);

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    AST_REQ_SETS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req[g] |=> ack_all[g]); // R2
    AST_ACK_MASKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ack_all[g] |-> !cpu_req[g]); // R2
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(ack_all[g]) && !$past(ack_wr && bus_wdata[g])) |-> ack_all[g]); // R3
  end

  AST_IRQ_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> ((flag_all | ~$past(irq_in)) == {NSRC{1'b1}})); // R6
  AST_RST_FETCH_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_rst |-> (fetch_region == RG_BOOT && int'(fetch_addr) == 'h3FFFC0)); // R8
  AST_DISABLED_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_rst && map_vec && !ctrl_q) |-> (fetch_region == RG_BOOT)); // R7
  AST_NONTABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_region != RG_EXP) |-> (fetch_vec == '0)); // R7
endmodule

bind irq_group_expander irq_exp_chk #(
  .NGRP(NGRP), .GSZ(GSZ), .VW(VW), .AW(AW), .PAW(PAW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sn),
  .irq_in       (irq_in),
  .flag_all     (flag_all),
  .ack_all      (ack_all),
  .cpu_req      (cpu_req),
  .ctrl_q       (ctrl_q),
  .fetch_rst    (fetch_rst),
  .map_vec      (map_vec),
  .fetch_region (fetch_region),
  .fetch_addr   (fetch_addr),
  .fetch_vec    (fetch_vec),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata)
);

// File: tb/sim_irq_group_expander.sv
module sim_irq_group_expander;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [95:0] irq_in;
  logic [11:0] cpu_req;
  logic        fetch_en, fetch_rst, map_vec;
  logic [3:0]  fetch_grp;
  logic [1:0]  fetch_region;
  logic [21:0] fetch_addr;
  logic [31:0] fetch_vec;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  irq_group_expander u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cpu_req(cpu_req),
    .fetch_en(fetch_en), .fetch_grp(fetch_grp), .fetch_rst(fetch_rst),
    .map_vec(map_vec), .fetch_region(fetch_region), .fetch_addr(fetch_addr),
    .fetch_vec(fetch_vec), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #10 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit [7:0]  m_flag [12];
  bit [7:0]  m_en   [12];
  bit [11:0] m_ack;
  bit        m_ctrl;
  bit [31:0] m_vec  [96];

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pick(int g);
    for (int s = 0; s < 8; s++) if (m_flag[g][s] && m_en[g][s]) return s;
    return -1;
  endfunction

  function automatic bit [31:0] m_read(int a);
    if (a == 0) return {31'd0, m_ctrl};
    if (a == 1) return {20'd0, m_ack};
    if (a >= 'h10 && a < 'h1C) return {24'd0, m_en[a - 'h10]};
    if (a >= 'h20 && a < 'h2C) return {24'd0, m_flag[a - 'h20]};
    if (a >= 'h80 && a < 'hE0) return m_vec[a - 'h80];
    return 0;
  endfunction

  task automatic compare();
    bit [11:0] e_req;
    int g, s, idx;
    bit [1:0]  e_reg;
    bit [21:0] e_addr;
    bit [31:0] e_vec;
    string tg;
    for (int k = 0; k < 12; k++) e_req[k] = (|(m_flag[k] & m_en[k])) && !m_ack[k];
    check(cpu_req === e_req, "R2 cpu_req", {20'd0, cpu_req}, {20'd0, e_req});
    g = int'(fetch_grp);
    s = pick(g);
    idx = g * 8 + ((s < 0) ? 0 : s);
    e_vec = 0;
    tg = "R7";
    if (fetch_rst) begin
      e_reg = 1; e_addr = 22'h3FFFC0; tg = "R8";
    end else if (!map_vec) begin
      e_reg = 0; e_addr = 22'(2 * (g + 1));
    end else if (!m_ctrl) begin
      e_reg = 1; e_addr = 22'h3FFFC0 + 22'(2 * (g + 1));
    end else begin
      e_reg = 2; e_addr = 22'h000D40 + 22'(2 * idx); e_vec = m_vec[idx];
      tg = (s < 0) ? "R5" : "R4";
    end
    check(fetch_region === e_reg, {tg, " region"}, {30'd0, fetch_region}, {30'd0, e_reg});
    check(fetch_addr === e_addr, {tg, " addr"}, {10'd0, fetch_addr}, {10'd0, e_addr});
    check(fetch_vec === e_vec, {tg, " vec"}, fetch_vec, e_vec);
    check(bus_rdata === m_read(int'(bus_addr)), {cur_req, " rdata"}, bus_rdata, m_read(int'(bus_addr)));
  endtask

  task automatic model_update();
    bit [11:0] req;
    bit [7:0]  clr [12];
    int a, g, s;
    a = int'(bus_addr);
    for (int k = 0; k < 12; k++) begin
      req[k] = (|(m_flag[k] & m_en[k])) && !m_ack[k];
      clr[k] = 0;
    end
    g = int'(fetch_grp);
    if (fetch_en && !fetch_rst && map_vec && m_ctrl && g < 12) begin
      s = pick(g);
      if (s >= 0) clr[g][s] = 1;
    end
    for (int k = 0; k < 12; k++) begin
      m_flag[k] = (m_flag[k] & ~clr[k]) | irq_in[k*8 +: 8];
      if (bus_we && a == 'h20 + k) m_flag[k] = m_flag[k] | bus_wdata[7:0];
      if (bus_we && a == 'h10 + k) m_en[k] = bus_wdata[7:0];
    end
    if (bus_we && a == 1) m_ack = m_ack & ~bus_wdata[11:0];
    m_ack = m_ack | req;
    if (bus_we && a == 0) m_ctrl = bus_wdata[0];
    if (bus_we && a >= 'h80 && a < 'hE0) m_vec[a - 'h80] = bus_wdata;
  endtask

  task automatic tick();
    #1 compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
    bus_we = 0; irq_in = '0; fetch_en = 0; fetch_rst = 0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_we = 1; bus_addr = 8'(a); bus_wdata = d; tick();
  endtask

  task automatic rd(int a, string tag);
    cur_req = tag; bus_addr = 8'(a); tick();
  endtask

  task automatic fetch(int g);
    fetch_grp = 4'(g); fetch_en = 1; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; irq_in = '0; fetch_en = 0; fetch_rst = 0; map_vec = 1;
    fetch_grp = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    for (int k = 0; k < 12; k++) begin m_flag[k] = 0; m_en[k] = 0; end
    m_ack = 0; m_ctrl = 0;
    for (int i = 0; i < 96; i++) m_vec[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // reset state: flags, control, acks (R1, R7, R3)
    rd('h20, "R1"); rd('h2B, "R1"); rd(0, "R7"); rd(1, "R3");

    // R9: fill and read back the vector table
    cur_req = "R9";
    for (int i = 0; i < 96; i++) wr('h80 + i, 32'hC0DE_0000 + 32'(i * 'h101));
    for (int k = 0; k < 12; k++) wr('h10 + k, (k == 5) ? 32'h0F : 32'hFF);
    rd('h80, "R9"); rd('hDF, "R9"); rd('h15, "R9"); rd('hE5, "R9");
    // disabled expander fetch goes to boot ROM (R7)
    fetch(2);
    wr(0, 1); rd(0, "R7");

    // R4: two pending in group 3, lowest wins
    cur_req = "R4";
    irq_in[3*8+5] = 1; irq_in[3*8+2] = 1; tick();
    tick();               // request then acknowledge
    fetch(3); rd('h23, "R4");
    fetch(3); rd('h23, "R4");
    // R5: nothing pending
    fetch(3); rd('h23, "R5");

    // R3: write 0 leaves ack, write 1 clears
    wr(1, 0); rd(1, "R3");
    irq_in[3*8+1] = 1; tick();
    rd(1, "R3");
    wr(1, 32'h8); tick(); rd(1, "R3");

    // R2: masked source raises nothing, enabling it does
    irq_in[5*8+6] = 1; tick(); rd('h25, "R2"); rd(1, "R2");
    wr('h15, 32'hFF); tick(); rd(1, "R2");

    // R6: set and fetch-clear collide
    irq_in[7*8+1] = 1; tick(); tick();
    fetch_grp = 7; fetch_en = 1; irq_in[7*8+1] = 1; tick();
    rd('h27, "R6");
    fetch(7); rd('h27, "R6");

    // R1: software set, write-1 only
    wr('h29, 32'h81); rd('h29, "R1");
    wr('h29, 32'h00); rd('h29, "R1");

    // R7: disabled expander then low RAM mode, no flag clears
    wr(0, 0); fetch(9); rd('h29, "R7");
    map_vec = 0; fetch(9); fetch(11); rd('h29, "R7");
    map_vec = 1; wr(0, 1); fetch(9); rd('h29, "R4");

    // R8: reset fetch always to boot ROM
    fetch_rst = 1; fetch(9); rd('h29, "R8");
    map_vec = 0; fetch_rst = 1; fetch(4); map_vec = 1;
    fetch(11); fetch(0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule